// File: doc/BRIEF.md
# Dynamic-Scheduling Scoreboard

This block is the central hazard tracker for a small out-of-order execution core. It keeps one status row per functional unit and a table that maps each architectural register to the unit that will produce its next value. The default machine has one integer unit, one adder, a configurable number of multipliers and one divider. Operand values and register storage are held elsewhere. The scoreboard handles only tags, ready flags and phases.

Instructions arrive one per cycle, in program order, as a class, an opcode, a destination and two sources. An instruction is accepted when a unit of its class is free and no unit already targets the same destination. Each accepted instruction then passes through three more phases. It waits for its operands and receives a one-cycle read grant when both sources are ready. It executes until its unit model pulses done. It then waits until writing its result cannot overwrite a value that an earlier instruction has yet to read, and receives a one-cycle write grant. Issue therefore stays in order, while execution and completion may finish in any order.

Top module: `dyn_scoreboard`

## Requirements
- R1: While reset is low and in the first cycle after it, every unit is idle: `unit_busy`, `rd_grant` and `wr_grant` are all zero, and `iss_accept` is zero while `iss_valid` is zero.
- R2: Issue is accepted in a cycle exactly when `iss_valid` is high, a unit of the requested class is idle and no busy unit targets `iss_dst`. Class codes are 0 integer, 1 adder, 2 multiplier and 3 divider. Units are numbered 0 integer, 1 adder, 2 to N_MUL+1 multipliers and N_MUL+2 divider. `iss_unit` gives the lowest-numbered idle unit of the class.
- R3: While any busy unit has the same destination as the offered instruction, issue stalls (WAW), even if a unit of the class is free.
- R4: A unit that receives a write grant in cycle t cannot be issued to in cycle t. It is idle from cycle t+1, and its destination no longer blocks issue from cycle t+1.
- R5: A unit waiting for operands gets a read grant in the first cycle in which both of its sources are ready. A source is ready if no unit was producing it at issue, or if its producer has since written. The grant lasts one cycle and moves the unit to execute.
- R6: While a unit is busy, its slice `unit_op[u*OP_W +: OP_W]` carries the opcode of the instruction it holds.
- R7: An `exec_done` pulse moves a unit from execute to waiting-to-write. A pulse on a unit in any other phase has no effect.
- R8: A unit waiting to write gets a write grant only when no other busy unit names its destination as a source that it has not yet read (WAR).
- R9: A write grant in cycle t makes the unit idle in cycle t+1 and marks every waiting consumer of that unit ready. Those consumers can be read-granted from cycle t+1.
- R10: An instruction issued in the same cycle in which its source's producer is write-granted treats that source as ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| iss_valid | input | 1 | An instruction is offered for issue |
| iss_cls | input | 2 | Unit class of the offered instruction |
| iss_op | input | OP_W | Opcode of the offered instruction |
| iss_dst | input | log2(N_REGS) | Destination register |
| iss_src1 | input | log2(N_REGS) | First source register |
| iss_src2 | input | log2(N_REGS) | Second source register |
| exec_done | input | N_UNITS | Per-unit end-of-execution pulse |
| iss_accept | output | 1 | The offered instruction issues this cycle |
| iss_unit | output | log2(N_UNITS) | Unit receiving the issued instruction |
| rd_grant | output | N_UNITS | Per-unit operand read grant |
| wr_grant | output | N_UNITS | Per-unit result write grant |
| unit_busy | output | N_UNITS | Per-unit busy flag |
| unit_op | output | N_UNITS*OP_W | Opcode held by each unit |

## Verification
The bench builds the block with N_MUL=2 and N_REGS=8. Two multipliers exercise the lowest-free-unit choice within a class and the structural stall that follows when both are taken. Eight registers make RAW, WAR and WAW collisions frequent in random code. Unit latencies of 1, 2, 4 and 8 cycles by class make completion out of order. Together these cause same-cycle write and issue, and write grants held back by slow readers, to happen often.

// File: rtl/dsb_pkg.sv
// Shared definitions for the scoreboard: unit phases, class codes and
// the fixed mapping of unit index to class. Assumes the unit order
// integer, adder, multipliers, divider.
package dsb_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_OPS  = 2'd1,
        PH_EXEC = 2'd2,
        PH_WB   = 2'd3
    } phase_e;

    localparam logic [1:0] CLS_INT = 2'd0;
    localparam logic [1:0] CLS_ADD = 2'd1;
    localparam logic [1:0] CLS_MUL = 2'd2;
    localparam logic [1:0] CLS_DIV = 2'd3;

    // Class of the unit at position idx, given the multiplier count.
    function automatic logic [1:0] unit_class(input int idx, input int n_mul);
        if (idx == 0)              return CLS_INT;
        else if (idx == 1)         return CLS_ADD;
        else if (idx < 2 + n_mul)  return CLS_MUL;
        else                       return CLS_DIV;
    endfunction

endpackage

// File: rtl/dsb_result_table.sv
// Register result table: one entry per architectural register, naming
// the unit that will write it. Entries set at issue, cleared when the
// owning unit is write-granted. Assumes set and clear never hit the
// same entry in one cycle (issue requires the entry clear).
module dsb_result_table #(
    parameter int N_REGS  = 16,
    parameter int N_UNITS = 5,
    parameter int UW      = 3,
    parameter int RW      = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               set_en,
    input  logic [RW-1:0]      set_reg,
    input  logic [UW-1:0]      set_unit,
    input  logic [N_UNITS-1:0] wr_all,
    input  logic [RW-1:0]      look_dst,
    input  logic [RW-1:0]      look_s1,
    input  logic [RW-1:0]      look_s2,
    output logic               dst_pend,
    output logic               s1_vld,
    output logic [UW-1:0]      s1_id,
    output logic               s2_vld,
    output logic [UW-1:0]      s2_id
);

    localparam int PADW = 1 << UW;

    logic          ent_vld [N_REGS];
    logic [UW-1:0] ent_id  [N_REGS];
    logic [PADW-1:0] wr_pad;

    // Widen the write vector so any tag value indexes safely.
    always_comb begin
        wr_pad = '0;
        wr_pad[N_UNITS-1:0] = wr_all;
    end

    // Update entries: clear on owner write, then set on issue.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < N_REGS; r++) begin
                ent_vld[r] <= 1'b0;
                ent_id[r]  <= '0;
            end
        end else begin
            for (int r = 0; r < N_REGS; r++) begin
                if (ent_vld[r] && wr_pad[ent_id[r]])
                    ent_vld[r] <= 1'b0;
            end
            if (set_en) begin
                ent_vld[set_reg] <= 1'b1;
                ent_id[set_reg]  <= set_unit;
            end
        end
    end

    // Lookups for the instruction offered at issue.
    always_comb begin
        dst_pend = ent_vld[look_dst];
        s1_vld   = ent_vld[look_s1];
        s1_id    = ent_id[look_s1];
        s2_vld   = ent_vld[look_s2];
        s2_id    = ent_id[look_s2];
    end

endmodule

// File: rtl/dsb_issue_ctl.sv
// Issue control: picks the lowest idle unit of the requested class,
// stalls on a busy class or a pending destination, and marks a source
// ready when its producer is written in the same cycle.
module dsb_issue_ctl
    import dsb_pkg::*;
#(
    parameter int N_UNITS = 5,
    parameter int N_MUL   = 2,
    parameter int UW      = 3
) (
    input  logic               iss_valid,
    input  logic [1:0]         iss_cls,
    input  logic [N_UNITS-1:0] unit_busy,
    input  logic [N_UNITS-1:0] wr_all,
    input  logic               dst_pend,
    input  logic               s1_vld,
    input  logic [UW-1:0]      s1_id,
    input  logic               s2_vld,
    input  logic [UW-1:0]      s2_id,
    output logic               accept,
    output logic [UW-1:0]      unit_id,
    output logic [N_UNITS-1:0] iss_onehot,
    output logic               q1_vld,
    output logic               q2_vld
);

    localparam int PADW = 1 << UW;

    logic            found;
    logic [PADW-1:0] wr_pad;

    // Scan from the top so the lowest matching unit wins.
    always_comb begin
        found   = 1'b0;
        unit_id = '0;
        for (int i = N_UNITS - 1; i >= 0; i--) begin
            if (!unit_busy[i] && unit_class(i, N_MUL) == iss_cls) begin
                found   = 1'b1;
                unit_id = UW'(i);
            end
        end
    end

    // Accept only with a free unit and no pending writer of the destination.
    always_comb begin
        accept     = iss_valid && found && !dst_pend;
        iss_onehot = '0;
        if (accept)
            iss_onehot[unit_id] = 1'b1;
    end

    // A producer being written this cycle no longer counts as pending.
    always_comb begin
        wr_pad = '0;
        wr_pad[N_UNITS-1:0] = wr_all;
        q1_vld = s1_vld && !wr_pad[s1_id];
        q2_vld = s2_vld && !wr_pad[s2_id];
    end

endmodule

// File: rtl/dsb_unit_row.sv
// One functional-unit status row: phase, opcode, destination and
// source registers, producer tags and ready flags. Produces its own
// read and write grants; the WAR clearance comes from the top.
module dsb_unit_row
    import dsb_pkg::*;
#(
    parameter int N_UNITS = 5,
    parameter int UW      = 3,
    parameter int RW      = 4,
    parameter int OP_W    = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               iss_en,
    input  logic [OP_W-1:0]    iss_op,
    input  logic [RW-1:0]      iss_dst,
    input  logic [RW-1:0]      iss_s1,
    input  logic [RW-1:0]      iss_s2,
    input  logic               iss_q1_vld,
    input  logic [UW-1:0]      iss_q1_id,
    input  logic               iss_q2_vld,
    input  logic [UW-1:0]      iss_q2_id,
    input  logic [N_UNITS-1:0] wr_all,
    input  logic               done_in,
    input  logic               war_ok,
    output logic               busy,
    output logic [OP_W-1:0]    op,
    output logic [RW-1:0]      fi,
    output logic [RW-1:0]      fj,
    output logic [RW-1:0]      fk,
    output logic               rj,
    output logic               rk,
    output logic               rd_go,
    output logic               wr_go
);

    localparam int PADW = 1 << UW;

    phase_e          phase;
    logic            qj_vld, qk_vld;
    logic [UW-1:0]   qj_id, qk_id;
    logic [PADW-1:0] wr_pad;

    // Widen the write vector for tag indexing.
    always_comb begin
        wr_pad = '0;
        wr_pad[N_UNITS-1:0] = wr_all;
    end

    // Grants follow from the phase and the ready/clearance flags.
    always_comb begin
        busy  = (phase != PH_IDLE);
        rd_go = (phase == PH_OPS) && rj && rk;
        wr_go = (phase == PH_WB) && war_ok;
    end

    // Phase sequencing through issue, operands, execute and write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
        end else begin
            unique case (phase)
                PH_IDLE: if (iss_en)  phase <= PH_OPS;
                PH_OPS:  if (rd_go)   phase <= PH_EXEC;
                PH_EXEC: if (done_in) phase <= PH_WB;
                PH_WB:   if (wr_go)   phase <= PH_IDLE;
                default:              phase <= PH_IDLE;
            endcase
        end
    end

    // Instruction fields captured at issue.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op <= '0;
            fi <= '0;
            fj <= '0;
            fk <= '0;
        end else if (iss_en) begin
            op <= iss_op;
            fi <= iss_dst;
            fj <= iss_s1;
            fk <= iss_s2;
        end
    end

    // First source tag and ready flag: set at issue, woken by writes, consumed by read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            qj_vld <= 1'b0;
            qj_id  <= '0;
            rj     <= 1'b0;
        end else if (iss_en) begin
            qj_vld <= iss_q1_vld;
            qj_id  <= iss_q1_id;
            rj     <= !iss_q1_vld;
        end else if (rd_go) begin
            rj <= 1'b0;
        end else if (qj_vld && wr_pad[qj_id]) begin
            qj_vld <= 1'b0;
            rj     <= 1'b1;
        end
    end

    // Second source tag and ready flag, same rules as the first.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            qk_vld <= 1'b0;
            qk_id  <= '0;
            rk     <= 1'b0;
        end else if (iss_en) begin
            qk_vld <= iss_q2_vld;
            qk_id  <= iss_q2_id;
            rk     <= !iss_q2_vld;
        end else if (rd_go) begin
            rk <= 1'b0;
        end else if (qk_vld && wr_pad[qk_id]) begin
            qk_vld <= 1'b0;
            rk     <= 1'b1;
        end
    end

endmodule

// File: rtl/dyn_scoreboard.sv
// Scoreboard top: per-unit status rows, the register result table,
// issue control and the WAR clearance network. Assumes the requester
// holds an offered instruction until it is accepted.
module dyn_scoreboard
    import dsb_pkg::*;
#(
    parameter int N_MUL  = 2,
    parameter int N_REGS = 16,
    parameter int OP_W   = 4,
    localparam int N_UNITS = 3 + N_MUL,
    localparam int UW      = $clog2(N_UNITS),
    localparam int RW      = $clog2(N_REGS)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      iss_valid,
    input  logic [1:0]                iss_cls,
    input  logic [OP_W-1:0]           iss_op,
    input  logic [RW-1:0]             iss_dst,
    input  logic [RW-1:0]             iss_src1,
    input  logic [RW-1:0]             iss_src2,
    input  logic [N_UNITS-1:0]        exec_done,
    output logic                      iss_accept,
    output logic [UW-1:0]             iss_unit,
    output logic [N_UNITS-1:0]        rd_grant,
    output logic [N_UNITS-1:0]        wr_grant,
    output logic [N_UNITS-1:0]        unit_busy,
    output logic [N_UNITS*OP_W-1:0]   unit_op
);

    logic [N_UNITS-1:0] iss_onehot;
    logic [N_UNITS-1:0] war_ok;
    logic               dst_pend, s1_vld, s2_vld, q1_vld, q2_vld;
    logic [UW-1:0]      s1_id, s2_id;
    logic [RW-1:0]      fi_a [N_UNITS];
    logic [RW-1:0]      fj_a [N_UNITS];
    logic [RW-1:0]      fk_a [N_UNITS];
    logic [N_UNITS-1:0] rj_a, rk_a;

    dsb_result_table #(
        .N_REGS (N_REGS),
        .N_UNITS(N_UNITS),
        .UW     (UW),
        .RW     (RW)
    ) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_en  (iss_accept),
        .set_reg (iss_dst),
        .set_unit(iss_unit),
        .wr_all  (wr_grant),
        .look_dst(iss_dst),
        .look_s1 (iss_src1),
        .look_s2 (iss_src2),
        .dst_pend(dst_pend),
        .s1_vld  (s1_vld),
        .s1_id   (s1_id),
        .s2_vld  (s2_vld),
        .s2_id   (s2_id)
    );

    dsb_issue_ctl #(
        .N_UNITS(N_UNITS),
        .N_MUL  (N_MUL),
        .UW     (UW)
    ) u_issue (
        .iss_valid (iss_valid),
        .iss_cls   (iss_cls),
        .unit_busy (unit_busy),
        .wr_all    (wr_grant),
        .dst_pend  (dst_pend),
        .s1_vld    (s1_vld),
        .s1_id     (s1_id),
        .s2_vld    (s2_vld),
        .s2_id     (s2_id),
        .accept    (iss_accept),
        .unit_id   (iss_unit),
        .iss_onehot(iss_onehot),
        .q1_vld    (q1_vld),
        .q2_vld    (q2_vld)
    );

    for (genvar u = 0; u < N_UNITS; u++) begin : g_row
        dsb_unit_row #(
            .N_UNITS(N_UNITS),
            .UW     (UW),
            .RW     (RW),
            .OP_W   (OP_W)
        ) u_row (
            .clk       (clk),
            .rst_n     (rst_n),
            .iss_en    (iss_onehot[u]),
            .iss_op    (iss_op),
            .iss_dst   (iss_dst),
            .iss_s1    (iss_src1),
            .iss_s2    (iss_src2),
            .iss_q1_vld(q1_vld),
            .iss_q1_id (s1_id),
            .iss_q2_vld(q2_vld),
            .iss_q2_id (s2_id),
            .wr_all    (wr_grant),
            .done_in   (exec_done[u]),
            .war_ok    (war_ok[u]),
            .busy      (unit_busy[u]),
            .op        (unit_op[u*OP_W +: OP_W]),
            .fi        (fi_a[u]),
            .fj        (fj_a[u]),
            .fk        (fk_a[u]),
            .rj        (rj_a[u]),
            .rk        (rk_a[u]),
            .rd_go     (rd_grant[u]),
            .wr_go     (wr_grant[u])
        );
    end

    // WAR clearance: no other busy unit still owes a read of this destination.
    always_comb begin
        for (int f = 0; f < N_UNITS; f++) begin
            war_ok[f] = 1'b1;
            for (int g = 0; g < N_UNITS; g++) begin
                if (g != f && unit_busy[g] &&
                    ((fj_a[g] == fi_a[f] && rj_a[g]) ||
                     (fk_a[g] == fi_a[f] && rk_a[g])))
                    war_ok[f] = 1'b0;
            end
        end
    end

endmodule

// File: rtl/dyn_scoreboard_chk.sv
// Checker for the scoreboard ports: grant exclusivity, unit freeing
// and issue targeting. Attached to every instance by bind.
module dyn_scoreboard_chk #(
    parameter int N_UNITS = 5,
    parameter int UW      = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               iss_valid,
    input logic               iss_accept,
    input logic [UW-1:0]      iss_unit,
    input logic [N_UNITS-1:0] rd_grant,
    input logic [N_UNITS-1:0] wr_grant,
    input logic [N_UNITS-1:0] unit_busy
);

    a_r2_accept_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        iss_accept |-> iss_valid);

    a_r2_issue_to_idle_unit: assert property (@(posedge clk) disable iff (!rst_n)
        iss_accept |-> !unit_busy[iss_unit]);

    a_r4_no_issue_into_writer: assert property (@(posedge clk) disable iff (!rst_n)
        iss_accept |-> !wr_grant[iss_unit]);

    a_r5_read_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_grant & ~unit_busy) == '0);

    a_r5_read_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (|rd_grant) |=> ((rd_grant & $past(rd_grant)) == '0));

    a_r7_read_write_apart: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_grant & wr_grant) == '0);

    a_r9_idle_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        (|wr_grant) |=> ((unit_busy & $past(wr_grant)) == '0));

endmodule

bind dyn_scoreboard dyn_scoreboard_chk #(
    .N_UNITS(N_UNITS),
    .UW     (UW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .iss_valid (iss_valid),
    .iss_accept(iss_accept),
    .iss_unit  (iss_unit),
    .rd_grant  (rd_grant),
    .wr_grant  (wr_grant),
    .unit_busy (unit_busy)
);

// File: tb/dyn_scoreboard_test.sv
// Bench: directed hazard sequence, then seeded random instructions,
// all compared each cycle against a behavioural status model.
module dyn_scoreboard_test;

    localparam int N_MUL = 2;
    localparam int N_REGS = 8;
    localparam int OP_W = 4;
    localparam int NU = 3 + N_MUL;
    localparam int UW = $clog2(NU);
    localparam int RW = $clog2(N_REGS);
    localparam int NCYC = 4000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic iss_valid = 1'b0;
    logic [1:0] iss_cls = '0;
    logic [OP_W-1:0] iss_op = '0;
    logic [RW-1:0] iss_dst = '0, iss_src1 = '0, iss_src2 = '0;
    logic [NU-1:0] exec_done = '0;
    logic iss_accept;
    logic [UW-1:0] iss_unit;
    logic [NU-1:0] rd_grant, wr_grant, unit_busy;
    logic [NU*OP_W-1:0] unit_op;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    dyn_scoreboard #(.N_MUL(N_MUL), .N_REGS(N_REGS), .OP_W(OP_W)) uut (
        .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_cls(iss_cls),
        .iss_op(iss_op), .iss_dst(iss_dst), .iss_src1(iss_src1),
        .iss_src2(iss_src2), .exec_done(exec_done), .iss_accept(iss_accept),
        .iss_unit(iss_unit), .rd_grant(rd_grant), .wr_grant(wr_grant),
        .unit_busy(unit_busy), .unit_op(unit_op)
    );

    // Behavioural model state
    int m_ph [NU];   // 0 idle, 1 operands, 2 execute, 3 write wait
    int m_op [NU];
    int m_fi [NU], m_fj [NU], m_fk [NU];
    int m_qj [NU], m_qk [NU];   // -1 when no producer
    bit m_rj [NU], m_rk [NU];
    int m_cnt [NU];
    int m_reg [N_REGS];         // producing unit or -1

    function automatic int cls_of(int u);
        if (u == 0) return 0;
        if (u == 1) return 1;
        if (u < 2 + N_MUL) return 2;
        return 3;
    endfunction

    function automatic int lat_of(int u);
        return 1 << cls_of(u);   // 1, 2, 4, 8 cycles
    endfunction

    function automatic bit exp_wr(int u);
        if (m_ph[u] != 3) return 0;
        for (int g = 0; g < NU; g++)
            if (g != u && m_ph[g] != 0 &&
                ((m_fj[g] == m_fi[u] && m_rj[g]) || (m_fk[g] == m_fi[u] && m_rk[g])))
                return 0;
        return 1;
    endfunction

    function automatic bit exp_rd(int u);
        return m_ph[u] == 1 && m_rj[u] && m_rk[u];
    endfunction

    function automatic int exp_unit(int cls);
        for (int u = 0; u < NU; u++)
            if (m_ph[u] == 0 && cls_of(u) == cls) return u;
        return -1;
    endfunction

    task automatic check(string req, string what, int got, int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
        end
    endtask

    // Pending instruction
    int p_cls, p_op, p_dst, p_s1, p_s2;
    int d_idx = 0;
    int dir_cls [8] = '{3, 1, 0, 2, 2, 2, 0, 1};
    int dir_dst [8] = '{1, 4, 5, 6, 7, 0, 1, 3};
    int dir_s1  [8] = '{2, 1, 6, 4, 0, 1, 3, 5};
    int dir_s2  [8] = '{3, 5, 7, 4, 0, 2, 3, 6};

    task automatic next_instr();
        if (d_idx < 8) begin
            // Directed: div r1; add reads r1 (RAW) and r5; int writes r5 (WAR);
            // three multiplies (structural); int rewrites r1 (WAW).
            p_cls = dir_cls[d_idx]; p_dst = dir_dst[d_idx];
            p_s1 = dir_s1[d_idx];   p_s2 = dir_s2[d_idx];
            p_op = d_idx + 1;
            d_idx++;
        end else begin
            p_cls = $urandom % 4;
            p_op  = $urandom % (1 << OP_W);
            p_dst = $urandom % N_REGS;
            p_s1  = $urandom % N_REGS;
            p_s2  = $urandom % N_REGS;
        end
    endtask

    initial begin
        #(200000 * 10);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5c0e_b0a7));
        for (int u = 0; u < NU; u++) begin
            m_ph[u] = 0; m_op[u] = 0; m_fi[u] = 0; m_fj[u] = 0; m_fk[u] = 0;
            m_qj[u] = -1; m_qk[u] = -1; m_rj[u] = 0; m_rk[u] = 0; m_cnt[u] = 0;
        end
        for (int r = 0; r < N_REGS; r++) m_reg[r] = -1;

        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: idle during reset
        check("R1", "busy in reset", int'(unit_busy), 0);
        check("R1", "rd_grant in reset", int'(rd_grant), 0);
        check("R1", "wr_grant in reset", int'(wr_grant), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "busy after reset", int'(unit_busy), 0);
        check("R1", "accept after reset", int'(iss_accept), 0);

        next_instr();
        for (int cyc = 0; cyc < NCYC; cyc++) begin
            bit e_rd [NU];
            bit e_wr [NU];
            bit dn [NU];
            bit vld;
            int eu;
            bit e_acc;
            int q1, q2;
            // Drive inputs away from the clock edge
            vld = (d_idx <= 8 && cyc < 40) ? 1'b1 : (($urandom % 4) != 0);
            for (int u = 0; u < NU; u++) begin
                dn[u] = (m_ph[u] == 2 && m_cnt[u] == 0);
                if (m_ph[u] != 2 && ($urandom % 8) == 0) dn[u] = 1'b1;  // R7 stray pulse
                exec_done[u] = dn[u];
            end
            iss_valid = vld;
            iss_cls = 2'(p_cls); iss_op = OP_W'(p_op);
            iss_dst = RW'(p_dst); iss_src1 = RW'(p_s1); iss_src2 = RW'(p_s2);
            #1;
            // Expected outputs from the model
            for (int u = 0; u < NU; u++) begin
                e_rd[u] = exp_rd(u);
                e_wr[u] = exp_wr(u);
            end
            eu = exp_unit(p_cls);
            e_acc = vld && eu >= 0 && m_reg[p_dst] < 0;   // R2, R3 (R4: writer not idle yet)
            check("R2 R3 R4", "iss_accept", int'(iss_accept), int'(e_acc));
            if (e_acc) check("R2", "iss_unit", int'(iss_unit), eu);
            for (int u = 0; u < NU; u++) begin
                check("R5 R10", $sformatf("rd_grant[%0d]", u), int'(rd_grant[u]), int'(e_rd[u]));
                check("R7 R8", $sformatf("wr_grant[%0d]", u), int'(wr_grant[u]), int'(e_wr[u]));
                check("R9 R4", $sformatf("unit_busy[%0d]", u), int'(unit_busy[u]), int'(m_ph[u] != 0));
                if (m_ph[u] != 0)
                    check("R6", $sformatf("unit_op[%0d]", u), int'(unit_op[u*OP_W +: OP_W]), m_op[u]);
            end
            // Advance the model to the state after this edge
            for (int r = 0; r < N_REGS; r++)
                if (m_reg[r] >= 0 && e_wr[m_reg[r]]) m_reg[r] = -1;
            for (int u = 0; u < NU; u++) begin
                if (e_wr[u]) begin
                    m_ph[u] = 0;
                end else if (e_rd[u]) begin
                    m_ph[u] = 2; m_rj[u] = 0; m_rk[u] = 0; m_cnt[u] = lat_of(u) - 1;
                end else if (m_ph[u] == 2) begin
                    if (dn[u]) m_ph[u] = 3;
                    else m_cnt[u]--;
                end
                if (m_ph[u] == 1 && !e_rd[u]) begin
                    if (m_qj[u] >= 0 && e_wr[m_qj[u]]) begin m_qj[u] = -1; m_rj[u] = 1; end
                    if (m_qk[u] >= 0 && e_wr[m_qk[u]]) begin m_qk[u] = -1; m_rk[u] = 1; end
                end
            end
            if (e_acc) begin
                q1 = m_reg[p_s1];
                q2 = m_reg[p_s2];
                if (q1 >= 0 && e_wr[q1]) q1 = -1;   // R10
                if (q2 >= 0 && e_wr[q2]) q2 = -1;
                m_ph[eu] = 1; m_op[eu] = p_op;
                m_fi[eu] = p_dst; m_fj[eu] = p_s1; m_fk[eu] = p_s2;
                m_qj[eu] = q1; m_qk[eu] = q2; m_rj[eu] = (q1 < 0); m_rk[eu] = (q2 < 0);
                m_reg[p_dst] = eu;
                next_instr();
            end
            @(negedge clk);
        end
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule